// File: doc/BRIEF.md
# Runtime Security Property Monitor

This block runs alongside a 32-bit processor and checks, every clock cycle, four behavioural security rules against probed processor signals. Each rule is a small automaton built from flip-flops with delay stages. It reports a per-rule result on the clock edge after the cycle it judged. A low result bit means the rule holds. A high bit means the rule was broken in the previous cycle.

The four rules cover these behaviours:
- user-mode fetches below the interrupt vector region;
- changes on the serial transmit data while its write strobe is idle;
- a network transmit nibble that appears without permission;
- edits to bit 0 of a debug value register outside privileged mode.

A sticky flag gathers every failure, so software or a supervisor circuit can latch that a breach happened at some point. The monitor has its own asynchronous reset. The probed processor reset is an ordinary data input and is used only as an exemption.

Top module: `sec_mon`

## Requirements
- R1: A fetch address `pc` below parameter `VEC_BASE` (default 32'h0000_2000) is a violation of the vector rule unless `cpu_rst` or `sup_mode` is high in that cycle or the exception window is open. An address equal to `VEC_BASE` or above it is never a violation.
- R2: The exception window opens in any cycle where `exc_start` is high while `pc` is below `VEC_BASE`, and that cycle is itself covered. The window stays open through the cycle in which `exc_ret` is high, including that cycle, and is closed from the next cycle on.
- R3: If `uart_we` is low in cycle t, then `uart_dout` in cycle t+2 must equal `uart_dout` in cycle t+1, otherwise the serial rule is violated. A change of the data at cycle t+1 is not a violation.
- R4: A nonzero `net_txd` is a violation of the network rule unless `net_tx_intent` or `sup_mode` is high in that cycle, or `net_txd0_valid` was high in the previous cycle. A zero nibble is never a violation.
- R5: A change of `dbg_bit0` from its value in the previous cycle is a violation of the debug rule unless `cpu_rst` or `sup_mode` is high in the cycle that shows the new value.
- R6: `fail_vec` holds one bit per rule: bit 0 for the vector rule, bit 1 for the serial rule, bit 2 for the network rule and bit 3 for the debug rule. A violation in cycle t raises its bit in cycle t+1 only, and the bit is low again when the next cycle has no violation.
- R7: While `rst_n` is low, all rule state, history and outputs are cleared. In the first cycle after reset release, the network and debug rules, which compare against the previous cycle, report no violation. With no violating activity every bit of `fail_vec` stays low.
- R8: `sticky_fail` rises one cycle after any bit of `fail_vec` is high and then stays high. `clr_sticky` clears it on the next edge, unless a bit of `fail_vec` is high in that same cycle, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low monitor reset |
| pc | input | 32 | Probed execute-stage fetch address |
| cpu_rst | input | 1 | Probed processor reset (exemption only) |
| sup_mode | input | 1 | Probed supervisor-mode flag |
| exc_start | input | 1 | Probed exception-entry pulse |
| exc_ret | input | 1 | Probed return-from-exception pulse |
| uart_we | input | 1 | Probed serial transmit write strobe |
| uart_dout | input | 8 | Probed serial transmit data |
| net_txd | input | 4 | Probed network transmit nibble |
| net_tx_intent | input | 1 | Probed transmit-permitted indication |
| net_txd0_valid | input | 1 | High when transmit data bit 0 is being driven |
| dbg_bit0 | input | 1 | Probed bit 0 of the debug value register |
| clr_sticky | input | 1 | Clears the sticky failure flag |
| fail_vec | output | 4 | Per-rule failure bits, one cycle after the violation |
| sticky_fail | output | 1 | Latched OR of all failure bits |

## Verification
The assertions assume that every probed input is a clean 0 or 1 on each sampled edge. Unknown drive on the network data bit therefore reaches the block only as a low `net_txd0_valid`. The assertions also assume that the inputs change only between edges. The stimulus drives all inputs on the falling edge from a single idle set of values. Each scenario moves only the inputs of the rule it targets and keeps the others in their non-violating state, so every expected failure bit can be attributed to exactly one rule.

// File: rtl/sec_mon_pkg.sv
package sec_mon_pkg;
    localparam int unsigned NPROP  = 4;
    localparam int unsigned P_VEC  = 0;
    localparam int unsigned P_UART = 1;
    localparam int unsigned P_NET  = 2;
    localparam int unsigned P_DBG  = 3;
endpackage

// File: rtl/vec_fetch_chk.sv
module vec_fetch_chk #(
    parameter int unsigned      PC_W     = 32,
    parameter logic [PC_W-1:0]  VEC_BASE = 32'h0000_2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc,
    input  logic            cpu_rst,
    input  logic            sup_mode,
    input  logic            exc_start,
    input  logic            exc_ret,
    output logic            fail
);
    typedef struct packed {
        logic win;
        logic fail;
    } vec_st_t;

    vec_st_t s_d, s_q;
    logic    below;
    logic    opening;
    logic    covered;

    always_comb begin
        below    = (pc < VEC_BASE);
        opening  = exc_start && below;
        covered  = s_q.win || opening;
        s_d      = s_q;
        s_d.win  = covered && !exc_ret;
        s_d.fail = below && !cpu_rst && !sup_mode && !covered;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fail = s_q.fail;

    AST_VEC_ABOVE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc < VEC_BASE) |=> !fail); // R1
    AST_VEC_PRIV_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_mode || cpu_rst) |=> !fail); // R1
    AST_VEC_WIN_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ret |=> !s_q.win); // R2
    AST_VEC_ENTRY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start |=> !fail); // R2
endmodule

// File: rtl/uart_stable_chk.sv
module uart_stable_chk #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uart_we,
    input  logic [DW-1:0] uart_dout,
    output logic          fail
);
    typedef struct packed {
        logic          idle1;
        logic          idle2;
        logic [DW-1:0] prev;
        logic          fail;
    } uart_st_t;

    uart_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.idle1 = !uart_we;
        s_d.idle2 = s_q.idle1;
        s_d.prev  = uart_dout;
        s_d.fail  = s_q.idle2 && (uart_dout != s_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fail = s_q.fail;

    AST_UART_STEADY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(uart_dout) |=> !fail); // R3
    AST_UART_STROBED_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uart_we, 2) |=> !fail); // R3
endmodule

// File: rtl/net_tx_chk.sv
module net_tx_chk #(
    parameter int unsigned NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] net_txd,
    input  logic             net_tx_intent,
    input  logic             sup_mode,
    input  logic             net_txd0_valid,
    output logic             fail
);
    typedef struct packed {
        logic primed;
        logic vprev;
        logic fail;
    } net_st_t;

    net_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.primed = 1'b1;
        s_d.vprev  = net_txd0_valid;
        s_d.fail   = s_q.primed && (net_txd != '0) && !net_tx_intent
                     && !sup_mode && !s_q.vprev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fail = s_q.fail;

    AST_NET_ZERO_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (net_txd == '0) |=> !fail); // R4
    AST_NET_PERMIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_intent || sup_mode) |=> !fail); // R4
    AST_NET_FIRST_OK: assert property (@(posedge clk)
        !rst_n |=> !fail); // R7
endmodule

// File: rtl/dbg_bit_chk.sv
module dbg_bit_chk (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_bit0,
    input  logic cpu_rst,
    input  logic sup_mode,
    output logic fail
);
    typedef struct packed {
        logic primed;
        logic bprev;
        logic fail;
    } dbg_st_t;

    dbg_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.primed = 1'b1;
        s_d.bprev  = dbg_bit0;
        s_d.fail   = s_q.primed && (dbg_bit0 != s_q.bprev) && !cpu_rst && !sup_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fail = s_q.fail;

    AST_DBG_STABLE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(dbg_bit0) |=> !fail); // R5
    AST_DBG_PRIV_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst || sup_mode) |=> !fail); // R5
endmodule

// File: rtl/sec_mon.sv
module sec_mon
    import sec_mon_pkg::*;
#(
    parameter int unsigned      PC_W     = 32,
    parameter logic [PC_W-1:0]  VEC_BASE = 32'h0000_2000,
    parameter int unsigned      UART_W   = 8,
    parameter int unsigned      NIB_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc,
    input  logic              cpu_rst,
    input  logic              sup_mode,
    input  logic              exc_start,
    input  logic              exc_ret,
    input  logic              uart_we,
    input  logic [UART_W-1:0] uart_dout,
    input  logic [NIB_W-1:0]  net_txd,
    input  logic              net_tx_intent,
    input  logic              net_txd0_valid,
    input  logic              dbg_bit0,
    input  logic              clr_sticky,
    output logic [NPROP-1:0]  fail_vec,
    output logic              sticky_fail
);
    typedef struct packed {
        logic sticky;
    } top_st_t;

    top_st_t          s_d, s_q;
    logic [NPROP-1:0] fails;

    vec_fetch_chk #(.PC_W(PC_W), .VEC_BASE(VEC_BASE)) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc       (pc),
        .cpu_rst  (cpu_rst),
        .sup_mode (sup_mode),
        .exc_start(exc_start),
        .exc_ret  (exc_ret),
        .fail     (fails[P_VEC])
    );

    uart_stable_chk #(.DW(UART_W)) u_uart (
        .clk      (clk),
        .rst_n    (rst_n),
        .uart_we  (uart_we),
        .uart_dout(uart_dout),
        .fail     (fails[P_UART])
    );

    net_tx_chk #(.NIB_W(NIB_W)) u_net (
        .clk           (clk),
        .rst_n         (rst_n),
        .net_txd       (net_txd),
        .net_tx_intent (net_tx_intent),
        .sup_mode      (sup_mode),
        .net_txd0_valid(net_txd0_valid),
        .fail          (fails[P_NET])
    );

    dbg_bit_chk u_dbg (
        .clk     (clk),
        .rst_n   (rst_n),
        .dbg_bit0(dbg_bit0),
        .cpu_rst (cpu_rst),
        .sup_mode(sup_mode),
        .fail    (fails[P_DBG])
    );

    always_comb begin
        s_d        = s_q;
        s_d.sticky = (s_q.sticky && !clr_sticky) || (|fails);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fail_vec    = fails;
    assign sticky_fail = s_q.sticky;

    AST_STICKY_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|fail_vec) |=> sticky_fail); // R8
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_fail && !clr_sticky) |=> sticky_fail); // R8
    AST_STICKY_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_fail) |-> $past(|fail_vec)); // R8
endmodule

// File: tb/sim_sec_mon.sv
module sim_sec_mon;
    localparam logic [31:0] BASE = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc;
    logic        cpu_rst, sup_mode, exc_start, exc_ret;
    logic        uart_we;
    logic [7:0]  uart_dout;
    logic [3:0]  net_txd;
    logic        net_tx_intent, net_txd0_valid, dbg_bit0, clr_sticky;
    logic [3:0]  fail_vec;
    logic        sticky_fail;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sec_mon u0 (
        .clk(clk), .rst_n(rst_n), .pc(pc), .cpu_rst(cpu_rst), .sup_mode(sup_mode),
        .exc_start(exc_start), .exc_ret(exc_ret), .uart_we(uart_we),
        .uart_dout(uart_dout), .net_txd(net_txd), .net_tx_intent(net_tx_intent),
        .net_txd0_valid(net_txd0_valid), .dbg_bit0(dbg_bit0),
        .clr_sticky(clr_sticky), .fail_vec(fail_vec), .sticky_fail(sticky_fail)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        pc = BASE + 32'h100; cpu_rst = 0; sup_mode = 0; exc_start = 0; exc_ret = 0;
        uart_we = 1; uart_dout = 8'h3C; net_txd = 0; net_tx_intent = 0;
        net_txd0_valid = 0; clr_sticky = 0;
    endtask

    task automatic t_reset();
        idle(); dbg_bit0 = 1; net_txd = 4'h5;
        rst_n = 0;
        step(); step();
        chk("R7 fails in reset", fail_vec, 4'h0);
        chk("R7 sticky in reset", sticky_fail, 1'b0);
        rst_n = 1;
        step();
        chk("R7 first cycle no history fail", fail_vec, 4'h0);
        step();
        chk("R4 nibble without permit", fail_vec, 4'b0100);
        net_txd = 0; step();
        chk("R6 bit drops after violation", fail_vec, 4'h0);
        clr_sticky = 1; step(); clr_sticky = 0; step();
    endtask

    task automatic t_vec();
        idle();
        pc = BASE - 1; step();
        chk("R1 user fetch below base", fail_vec, 4'b0001);
        pc = BASE; step();
        chk("R1 fetch at base", fail_vec, 4'h0);
        pc = BASE - 4; sup_mode = 1; step();
        chk("R1 supervisor exempt", fail_vec, 4'h0);
        sup_mode = 0; cpu_rst = 1; step();
        chk("R1 cpu reset exempt", fail_vec, 4'h0);
        cpu_rst = 0; exc_start = 1; step();
        chk("R2 window opening cycle", fail_vec, 4'h0);
        exc_start = 0; step();
        chk("R2 window open", fail_vec, 4'h0);
        exc_ret = 1; step();
        chk("R2 return cycle inclusive", fail_vec, 4'h0);
        exc_ret = 0; step();
        chk("R2 window closed after return", fail_vec, 4'b0001);
        pc = BASE + 32'h40; exc_start = 1; step();
        exc_start = 0; pc = BASE - 8; step();
        chk("R2 entry above base opens nothing", fail_vec, 4'b0001);
        idle(); step();
    endtask

    task automatic t_uart();
        idle(); step();
        uart_we = 0; step();
        uart_we = 1; step();
        uart_dout = 8'h55; step();
        chk("R3 data changed two after idle strobe", fail_vec, 4'b0010);
        step();
        chk("R3 steady data", fail_vec, 4'h0);
        uart_we = 0; step();
        uart_we = 1; uart_dout = 8'hAA; step();
        chk("R3 change at t+1 allowed", fail_vec, 4'h0);
        step();
        chk("R3 steady at t+2", fail_vec, 4'h0);
        uart_dout = 8'h11; step();
        uart_dout = 8'h22; step();
        chk("R3 changes while strobed", fail_vec, 4'h0);
        idle(); step(); step();
    endtask

    task automatic t_net();
        idle(); step();
        net_txd = 4'h8; net_tx_intent = 1; step();
        chk("R4 intent permits", fail_vec, 4'h0);
        net_tx_intent = 0; sup_mode = 1; step();
        chk("R4 supervisor permits", fail_vec, 4'h0);
        sup_mode = 0; net_txd = 0; net_txd0_valid = 1; step();
        chk("R4 zero nibble", fail_vec, 4'h0);
        net_txd = 4'h3; net_txd0_valid = 0; step();
        chk("R4 driven previous cycle permits", fail_vec, 4'h0);
        step();
        chk("R4 undriven previous cycle", fail_vec, 4'b0100);
        idle(); step();
    endtask

    task automatic t_dbg();
        idle(); step();
        dbg_bit0 = ~dbg_bit0; step();
        chk("R5 user flip", fail_vec, 4'b1000);
        step();
        chk("R5 steady bit", fail_vec, 4'h0);
        sup_mode = 1; dbg_bit0 = ~dbg_bit0; step();
        chk("R5 supervisor flip", fail_vec, 4'h0);
        sup_mode = 0; cpu_rst = 1; dbg_bit0 = ~dbg_bit0; step();
        chk("R5 cpu reset flip", fail_vec, 4'h0);
        idle(); step();
    endtask

    task automatic t_sticky();
        idle(); clr_sticky = 1; step(); clr_sticky = 0; step();
        chk("R8 cleared", sticky_fail, 1'b0);
        dbg_bit0 = ~dbg_bit0; step();
        chk("R8 not yet set", sticky_fail, 1'b0);
        step();
        chk("R8 set after fail", sticky_fail, 1'b1);
        step(); step();
        chk("R8 stays set", sticky_fail, 1'b1);
        clr_sticky = 1; step(); clr_sticky = 0;
        chk("R8 clear works", sticky_fail, 1'b0);
        dbg_bit0 = ~dbg_bit0; step();
        clr_sticky = 1; step(); clr_sticky = 0;
        chk("R8 new fail beats clear", sticky_fail, 1'b1);
        step(); step();
        chk("R7 quiet run keeps bits low", fail_vec, 4'h0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        t_reset();
        t_vec();
        t_uart();
        t_net();
        t_dbg();
        t_sticky();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end
endmodule